// File: doc/BRIEF.md
# Daisy-Chained Serial DAC Driver

This block refreshes every converter in a chain of serial DACs through one serial data line. The converters are wired in series: the serial output of each device drives the serial input of the next, while the serial clock and a shared load strobe reach all of them in parallel. A single start command latches one code per device. The block then shifts all of the codes out as one unbroken stream and raises the load strobe, so that every converter moves to its new value in the same instant.

There is no per-device addressing. Every update is a full pass of `WORD_W * N_DEV` bits followed by one load pulse, even when only one code has changed. The time an update takes therefore grows with the length of the chain. The serial clock runs at the system clock divided by `2 * HALF_DIV`.

Top module: `dac_chain_driver`

## Requirements
- R1: After synchronous reset, `busy`, `sclk`, `load` and `sdata` are all low. While `busy` is low, `sclk` and `load` stay low.
- R2: A `start` sampled while idle begins an update. `busy` is high from the next cycle and stays high for exactly `(2*T + 4) * HALF_DIV` cycles, where `T = WORD_W * N_DEV`.
- R3: Each update produces exactly `T` rising edges on `sclk`. Each half period of `sclk` lasts `HALF_DIV` system cycles.
- R4: Stream order: `codes[i*WORD_W +: WORD_W]` is the code for device `i`, and device 0 is the one nearest the driver. The code of device `N_DEV-1` is sent first, and each code is sent MSB first. The value on `sdata` at rising edge `k` is bit `T-1-k` of `codes`. `sdata` changes only while `sclk` is low.
- R5: `load` rises `2*HALF_DIV` cycles after the last falling edge of `sclk`. It stays high for `2*HALF_DIV` cycles, with `sclk` low throughout, and occurs exactly once per update.
- R6: A `start` that arrives while `busy` is high is ignored: the stream, the pulse count and the busy length are unchanged.
- R7: After an update, every chained device presents its own code. Device outputs keep their previous values until the load pulse.
- R8: `codes` is sampled only on the accepted `start`. Changes to `codes` during an update have no effect on that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an update, single cycle |
| codes | input | WORD_W*N_DEV | Packed codes, device i at bits [i*WORD_W +: WORD_W] |
| busy | output | 1 | High while an update is in progress |
| sclk | output | 1 | Serial clock shared by all devices, idles low |
| sdata | output | 1 | Serial data into the first device of the chain |
| load | output | 1 | Shared load strobe, active high |

## Verification
The bench drives a model of the device chain and compares each device's output to its intended code. A design that reversed the word order or the bit order would leave the codes on the wrong devices, or mirrored. It also counts clock edges and cycles. An off-by-one in the bit counter shows up as the wrong edge count and shifted codes, and a load issued without its setup gap shows up as a short gap. Mid-update restarts and changes to `codes` during an update are tested: a design that accepted either would lengthen `busy` or corrupt the stream. A load pulse issued too early is caught by checking that device outputs still hold their old values just before the strobe.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_LOAD  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/half_tick_gen.sv
module half_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  // count system cycles inside one serial half period
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == LAST);

  // R3: divider never leaves its range
  a_r3_div_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/stream_shifter.sv
module stream_shifter #(
  parameter int TOTAL = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [TOTAL-1:0] data_in,
  input  logic             advance,
  output logic             bit_out
);
  logic [TOTAL-1:0] sr_q;

  // MSB of the packed vector is the first bit on the line
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (capture) begin
      sr_q <= data_in;
    end else if (advance) begin
      sr_q <= {sr_q[TOTAL-2:0], 1'b0};
    end
  end

  assign bit_out = sr_q[TOTAL-1];

  // R8: the stream only moves on capture or advance
  a_r8_hold_stream: assert property (@(posedge clk) disable iff (rst)
    (!capture && !advance) |=> $stable(sr_q));

endmodule

// File: rtl/chain_seq_fsm.sv
module chain_seq_fsm
  import dac_chain_pkg::*;
#(
  parameter int TOTAL = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic capture,
  output logic advance,
  output logic busy,
  output logic sclk,
  output logic load
);
  localparam int BW = $clog2(TOTAL + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(TOTAL - 1);

  seq_state_t     state_q;
  logic [BW-1:0]  bit_q;
  logic           phase_q;   // 0: sclk low half, 1: sclk high half
  logic           half_q;    // half-period index in gap and load
  logic           busy_q, sclk_q, load_q;

  assign capture = (state_q == ST_IDLE) && start;
  assign advance = (state_q == ST_SHIFT) && tick && phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      phase_q <= 1'b0;
      half_q  <= 1'b0;
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SHIFT;
            busy_q  <= 1'b1;
            bit_q   <= '0;
            phase_q <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!phase_q) begin
              sclk_q  <= 1'b1;
              phase_q <= 1'b1;
            end else begin
              sclk_q  <= 1'b0;
              phase_q <= 1'b0;
              if (bit_q == LAST_BIT) begin
                state_q <= ST_GAP;
                half_q  <= 1'b0;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (half_q) begin
              state_q <= ST_LOAD;
              load_q  <= 1'b1;
              half_q  <= 1'b0;
            end else begin
              half_q <= 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (tick) begin
            if (half_q) begin
              state_q <= ST_IDLE;
              load_q  <= 1'b0;
              busy_q  <= 1'b0;
              half_q  <= 1'b0;
            end else begin
              half_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign load = load_q;

  // R1: quiet lines when idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!sclk_q && !load_q));
  // R5: strobe only while the serial clock rests low
  a_r5_load_clock_low: assert property (@(posedge clk) disable iff (rst)
    load_q |-> !sclk_q);
  // R2: strobe lies inside the busy window
  a_r2_load_in_busy: assert property (@(posedge clk) disable iff (rst)
    load_q |-> busy_q);
  // R3: bit counter bounded by the stream length
  a_r3_bit_bound: assert property (@(posedge clk) disable iff (rst)
    bit_q <= LAST_BIT);
  // R6: a start while shifting does not end or restart the update
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT && start && !tick) |=> (state_q == ST_SHIFT && $stable(bit_q)));

endmodule

// File: rtl/dac_chain_driver.sv
module dac_chain_driver #(
  parameter int WORD_W   = 12,
  parameter int N_DEV    = 4,
  parameter int HALF_DIV = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [WORD_W*N_DEV-1:0]   codes,
  output logic                      busy,
  output logic                      sclk,
  output logic                      sdata,
  output logic                      load
);
  localparam int TOTAL = WORD_W * N_DEV;

  logic tick, capture, advance;

  half_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (busy),
    .tick (tick)
  );

  chain_seq_fsm #(.TOTAL(TOTAL)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .tick    (tick),
    .capture (capture),
    .advance (advance),
    .busy    (busy),
    .sclk    (sclk),
    .load    (load)
  );

  stream_shifter #(.TOTAL(TOTAL)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .data_in (codes),
    .advance (advance),
    .bit_out (sdata)
  );

  // R4: data only moves while the serial clock is low
  a_r4_data_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata));

endmodule

// File: tb/dac_chain_model.sv
module dac_cell_model #(
  parameter int WORD_W = 12
) (
  input  logic              sclk,
  input  logic              load,
  input  logic              sdi,
  output logic              sdo,
  output logic [WORD_W-1:0] value
);
  logic [WORD_W-1:0] sr = '0;
  logic [WORD_W-1:0] out_q = '0;

  always_ff @(posedge sclk) sr <= {sr[WORD_W-2:0], sdi};
  always_ff @(posedge load) out_q <= sr;

  assign sdo   = sr[WORD_W-1];
  assign value = out_q;
endmodule

module dac_chain_model #(
  parameter int WORD_W = 12,
  parameter int N_DEV  = 4
) (
  input  logic                    sclk,
  input  logic                    load,
  input  logic                    sdi,
  output logic [WORD_W*N_DEV-1:0] values
);
  logic [N_DEV:0] link;
  assign link[0] = sdi;

  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    dac_cell_model #(.WORD_W(WORD_W)) u_cell (
      .sclk  (sclk),
      .load  (load),
      .sdi   (link[i]),
      .sdo   (link[i+1]),
      .value (values[i*WORD_W +: WORD_W])
    );
  end
endmodule

// File: tb/test_dac_chain_driver.sv
module test_dac_chain_driver;
  localparam int W  = 12;
  localparam int ND = 4;
  localparam int H  = 2;
  localparam int T  = W * ND;
  localparam int BUSY_LEN = (2 * T + 4) * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [T-1:0] codes = '0;
  logic busy, sclk, sdata, load;
  logic [T-1:0] dev_out;

  int n_checks = 0;
  int n_fail = 0;
  logic [T-1:0] last_codes = '0;

  always #5 clk = ~clk;

  dac_chain_driver #(.WORD_W(W), .N_DEV(ND), .HALF_DIV(H)) i_dac_chain_driver (
    .clk(clk), .rst(rst), .start(start), .codes(codes),
    .busy(busy), .sclk(sclk), .sdata(sdata), .load(load)
  );

  dac_chain_model #(.WORD_W(W), .N_DEV(ND)) u_model (
    .sclk(sclk), .load(load), .sdi(sdata), .values(dev_out)
  );

  localparam logic [T-1:0] VEC [0:5] = '{
    48'h123_456_789_ABC,
    48'hFFF_FFF_FFF_FFF,
    48'h000_000_000_000,
    48'h800_001_800_001,
    48'hA5A_5A5_5A5_A5A,
    48'h0FF_F00_F0F_0F0
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [T-1:0] act, input logic [T-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // mode 0: plain, 1: extra start mid-run (R6), 2: codes change mid-run (R8)
  task automatic run_update(input logic [T-1:0] c, input int mode);
    int cyc = 0, rises = 0, load_cyc = 0, load_rises = 0;
    int last_high = -1, load_first = -1;
    logic prev_sclk = 1'b0, prev_load = 1'b0;
    logic [T-1:0] cap = '0;
    logic [T-1:0] prev_out;
    bit held_ok = 1'b1;
    @(negedge clk);
    codes = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev_out = dev_out;
    while (busy && cyc < 4 * BUSY_LEN) begin
      cyc++;
      if (sclk && !prev_sclk) begin
        rises++;
        cap = {cap[T-2:0], sdata};
      end
      if (sclk) last_high = cyc;
      if (load) load_cyc++;
      if (load && !prev_load) begin
        load_rises++;
        if (load_first < 0) begin
          load_first = cyc;
          held_ok = (prev_out == last_codes);
        end
      end
      prev_sclk = sclk;
      prev_load = load;
      prev_out = dev_out;
      if (mode == 1 && cyc == 30) start = 1'b1;
      if (mode == 1 && cyc == 31) start = 1'b0;
      if (mode == 2 && cyc == 20) codes = ~c;
      @(negedge clk);
    end
    chk(cyc == BUSY_LEN, "R2", "busy length", T'(cyc), T'(BUSY_LEN));
    chk(rises == T, "R3", "sclk rising edges", T'(rises), T'(T));
    chk(cap == c, "R4", "stream order", cap, c);
    chk(load_rises == 1 && load_cyc == 2 * H, "R5", "load width",
        T'(load_cyc), T'(2 * H));
    chk(load_first - last_high == 2 * H + 1, "R5", "load setup gap",
        T'(load_first - last_high), T'(2 * H + 1));
    chk(held_ok, "R7", "outputs held before load", prev_out, last_codes);
    chk(dev_out == c, "R7", "device outputs", dev_out, c);
    if (mode == 1) chk(!busy && cyc == BUSY_LEN, "R6", "start while busy ignored",
                       T'(cyc), T'(BUSY_LEN));
    if (mode == 2) chk(dev_out == c, "R8", "codes change ignored", dev_out, c);
    last_codes = c;
    codes = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !sclk && !load && !sdata, "R1", "reset outputs",
        T'({busy, sclk, load, sdata}), '0);
    repeat (5) @(negedge clk);
    chk(!busy && !sclk && !load, "R1", "idle quiet",
        T'({busy, sclk, load}), '0);

    for (int i = 0; i < 6; i++) run_update(VEC[i], 0);

    // R6: extra start in the middle of an update
    run_update(48'h3C3_C3C_123_321, 1);
    // R8: codes altered during an update
    run_update(48'h5A5_0F0_ABC_DEF, 2);

    @(negedge clk);
    chk(!busy && !sclk && !load, "R1", "idle after updates",
        T'({busy, sclk, load}), '0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule